// File: doc/BRIEF.md
# Performance Counter Bank with Dual Write Windows

This block holds a set of general-purpose event counters, each a parameterized number of bits wide, and exposes them on a simple register bus. The bus has an address, 64-bit write data, a write strobe, combinational read data and an error flag. Every counter can be reached at two addresses.

The first address belongs to a narrow-write window. A write there takes only the low 32 bits of the data, sign-extends them from bit 31 and truncates the result to the counter width. The second address belongs to a wide-write window. A write there stores the whole value, as long as the value fits in the counter. A wider value is refused with an error and leaves the counter untouched.

Each counter advances by one in any cycle where both its event input and its enable are high. A counter that passes its all-ones value wraps to zero and raises a sticky flag in a shared overflow status register. Software clears that flag by writing one to it. A capability register tells software that the wide window exists. A separate indexed port reads any counter without using the bus.

Top module: `perfctr_bank`

## Requirements
- R1: Counter n is read and written at address 0x0C1+n in the narrow window and at 0x4C1+n in the wide window. Both addresses reach the same stored value, so a read through either one returns the same data, zero-extended to 64 bits.
- R2: A write through the narrow window stores data bits [31:0] sign-extended from bit 31 and truncated to CTR_W bits. For example, 0x80000001 stores 0xFFFF80000001 when CTR_W is 48.
- R3: A write through the narrow window with data bits [63:32] non-zero raises no error, and those upper bits have no effect on the stored value.
- R4: A write through the wide window whose data has no bit set at or above position CTR_W stores the data unchanged and raises no error.
- R5: A write through the wide window with any data bit set at or above position CTR_W drives bus_err high in the write cycle and leaves the counter unchanged.
- R6: The capability register at address 0x345 reads 0x2000: bit 13 is set to report that the wide window exists, and every other bit is zero.
- R7: rd_data returns the counter selected by rd_idx, zero-extended to 64 bits, with no bit set at or above CTR_W.
- R8: A counter increments by one on each clock edge at which its evt_inc bit and its ctr_en bit are both 1. It holds its value if either bit is 0.
- R9: A bus write takes effect at the clock edge that follows it, even while the counter is counting, and later increments continue from the written value. If a write and an increment reach the same counter at the same edge, the write wins.
- R10: A counter at all-ones (CTR_W bits) that increments wraps to zero and sets its bit n in the overflow status register at address 0x390.
- R11: Overflow status bits are sticky. A write to 0x390 clears exactly the bits whose data bit is 1. If a wrap and a clear hit the same bit at the same edge, the bit stays set.
- R12: Any address outside the counter windows, the capability register and the status register reads zero. A write there changes nothing and raises no error. This includes 0x0C0, 0x0C1+NUM_CTR, 0x4C0 and 0x4C1+NUM_CTR.
- R13: After reset, every counter and every overflow status bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 64 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| bus_err | output | 1 | Error response for a rejected wide-window write |
| evt_inc | input | NUM_CTR | Per-counter event pulse |
| ctr_en | input | NUM_CTR | Per-counter count enable |
| rd_idx | input | IDX_W | Counter index for the side read port |
| rd_data | output | 64 | Selected counter value, zero-extended |

## Verification
The bench writes a set of data patterns to every counter through both windows. The patterns are: zero, a small positive value, a value with bit 31 set, all-ones in 32 bits, a value that fits in 48 bits but not in 32, a value with garbage above bit 47, and a value with only bit 48 set. Each result is read back through both windows and through the side port. This separates sign extension from plain truncation, and it separates a rejected write from one that is accepted with upper bits masked off.

Counting is tried with the enable alone, the event alone and both together, which shows that increments are gated by both inputs. A write is issued in the same cycle as an increment, which shows that the write takes priority. Wraps are started from an all-ones value loaded through each window. The status register is then cleared, first with a zero mask and then with the matching bit, to separate sticky behaviour from write-one-to-clear. Addresses one step outside each window boundary confirm that nothing is aliased there.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int unsigned BUS_W   = 64;
  localparam int unsigned CAP_BIT = 13;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_NARROW,
    WIN_WIDE,
    WIN_CAP,
    WIN_OVF
  } win_e;

  // All-ones mask covering the low w bits of a bus word.
  function automatic logic [BUS_W-1:0] width_mask(input int unsigned w);
    if (w >= BUS_W) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  // Narrow-window value: low word sign-extended, then cut to w bits.
  function automatic logic [BUS_W-1:0] narrow_fold(input logic [BUS_W-1:0] d,
                                                   input int unsigned w);
    return {{32{d[31]}}, d[31:0]} & width_mask(w);
  endfunction

  // True when the data carries bits the counter cannot hold.
  function automatic logic beyond_width(input logic [BUS_W-1:0] d,
                                        input int unsigned w);
    return |(d & ~width_mask(w));
  endfunction

endpackage

// File: rtl/pcb_decode.sv
module pcb_decode #(
  parameter int unsigned NUM_CTR    = 4,
  parameter int unsigned CTR_W      = 48,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NARROW_BASE = 32'h0C1,
  parameter int unsigned WIDE_BASE   = 32'h4C1,
  parameter int unsigned CAP_ADDR    = 32'h345,
  parameter int unsigned OVF_ADDR    = 32'h390,
  localparam int unsigned IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [pcb_pkg::BUS_W-1:0] bus_wdata,
  input  logic                     bus_we,
  output pcb_pkg::win_e            win,
  output logic [IDX_W-1:0]         idx,
  output logic                     too_wide,
  output logic [NUM_CTR-1:0]       wr_sel,
  output logic [CTR_W-1:0]         wr_val
);
  import pcb_pkg::*;

  logic [31:0]      addr32;
  logic [31:0]      offset;
  logic [BUS_W-1:0] folded;

  assign addr32 = 32'(bus_addr);

  always_comb begin
    win    = WIN_NONE;
    offset = '0;
    if (addr32 >= NARROW_BASE && addr32 < NARROW_BASE + NUM_CTR) begin
      win    = WIN_NARROW;
      offset = addr32 - NARROW_BASE;
    end else if (addr32 >= WIDE_BASE && addr32 < WIDE_BASE + NUM_CTR) begin
      win    = WIN_WIDE;
      offset = addr32 - WIDE_BASE;
    end else if (addr32 == CAP_ADDR) begin
      win = WIN_CAP;
    end else if (addr32 == OVF_ADDR) begin
      win = WIN_OVF;
    end
  end

  assign idx      = offset[IDX_W-1:0];
  assign too_wide = beyond_width(bus_wdata, CTR_W);
  assign folded   = (win == WIN_NARROW) ? narrow_fold(bus_wdata, CTR_W)
                                        : (bus_wdata & width_mask(CTR_W));
  assign wr_val   = folded[CTR_W-1:0];

  always_comb begin
    for (int i = 0; i < int'(NUM_CTR); i++) begin
      wr_sel[i] = bus_we && (32'(idx) == 32'(i)) &&
                  ((win == WIN_NARROW) || (win == WIN_WIDE && !too_wide));
    end
  end

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int unsigned CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_val,
  input  logic             inc,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap
);

  // A wrap happens only when an increment is not pre-empted by a write.
  assign wrap = inc && !wr_en && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_val;
    else if (inc)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pcb_ovf.sv
module pcb_ovf #(
  parameter int unsigned NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap,
  input  logic               clr_en,
  input  logic [NUM_CTR-1:0] clr_mask,
  output logic [NUM_CTR-1:0] status
);

  logic [NUM_CTR-1:0] keep;

  assign keep = clr_en ? ~clr_mask : '1;

  // New wraps are ORed in after the clear, so a set beats a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & keep) | wrap;
  end

endmodule

// File: rtl/perfctr_bank.sv
module perfctr_bank #(
  parameter int unsigned NUM_CTR     = 4,
  parameter int unsigned CTR_W       = 48,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NARROW_BASE = 32'h0C1,
  parameter int unsigned WIDE_BASE   = 32'h4C1,
  parameter int unsigned CAP_ADDR    = 32'h345,
  parameter int unsigned OVF_ADDR    = 32'h390,
  localparam int unsigned IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [63:0]        bus_wdata,
  input  logic               bus_we,
  output logic [63:0]        bus_rdata,
  output logic               bus_err,
  input  logic [NUM_CTR-1:0] evt_inc,
  input  logic [NUM_CTR-1:0] ctr_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [63:0]        rd_data
);
  import pcb_pkg::*;

  win_e                          win;
  logic [IDX_W-1:0]              idx;
  logic                          too_wide;
  logic [NUM_CTR-1:0]            wr_sel;
  logic [CTR_W-1:0]              wr_val;
  logic [NUM_CTR-1:0]            inc_fire;
  logic [NUM_CTR-1:0]            wrap;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
  logic [NUM_CTR-1:0]            ovf_status;
  logic                          ovf_clr;

  pcb_decode #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W),
    .NARROW_BASE(NARROW_BASE), .WIDE_BASE(WIDE_BASE),
    .CAP_ADDR(CAP_ADDR), .OVF_ADDR(OVF_ADDR)
  ) u_decode (
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .win      (win),
    .idx      (idx),
    .too_wide (too_wide),
    .wr_sel   (wr_sel),
    .wr_val   (wr_val)
  );

  assign inc_fire = evt_inc & ctr_en;

  for (genvar g = 0; g < int'(NUM_CTR); g++) begin : g_ctr
    pcb_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_sel[g]),
      .wr_val(wr_val),
      .inc   (inc_fire[g]),
      .cnt   (ctr_q[g]),
      .wrap  (wrap[g])
    );
  end

  assign ovf_clr = bus_we && (win == WIN_OVF);

  pcb_ovf #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .clr_en  (ovf_clr),
    .clr_mask(bus_wdata[NUM_CTR-1:0]),
    .status  (ovf_status)
  );

  assign bus_err = bus_we && (win == WIN_WIDE) && too_wide;

  always_comb begin
    bus_rdata = '0;
    case (win)
      WIN_NARROW, WIN_WIDE: bus_rdata = BUS_W'(ctr_q[idx]);
      WIN_CAP:              bus_rdata[CAP_BIT] = 1'b1;
      WIN_OVF:              bus_rdata = BUS_W'(ovf_status);
      default:              bus_rdata = '0;
    endcase
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_idx) < NUM_CTR) rd_data = BUS_W'(ctr_q[rd_idx]);
  end

endmodule

// File: rtl/perfctr_bank_chk.sv
module perfctr_bank_chk #(
  parameter int unsigned NUM_CTR     = 4,
  parameter int unsigned CTR_W       = 48,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NARROW_BASE = 32'h0C1,
  parameter int unsigned WIDE_BASE   = 32'h4C1,
  parameter int unsigned CAP_ADDR    = 32'h345,
  parameter int unsigned OVF_ADDR    = 32'h390
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_we,
  input logic                          bus_err,
  input logic [63:0]                   bus_rdata,
  input logic [NUM_CTR-1:0]            evt_inc,
  input logic [NUM_CTR-1:0]            ctr_en,
  input logic [63:0]                   rd_data,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q,
  input logic [NUM_CTR-1:0]            wrap,
  input logic [NUM_CTR-1:0]            ovf_status
);
  localparam logic [63:0] WMASK = pcb_pkg::width_mask(CTR_W);

  logic [31:0] a;
  logic        in_wide;
  logic        mapped;
  logic        any_inc;

  assign a       = 32'(bus_addr);
  assign in_wide = (a >= WIDE_BASE) && (a < WIDE_BASE + NUM_CTR);
  assign mapped  = in_wide || ((a >= NARROW_BASE) && (a < NARROW_BASE + NUM_CTR)) ||
                   (a == CAP_ADDR) || (a == OVF_ADDR);
  assign any_inc = |(evt_inc & ctr_en);

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !any_inc) |=> $stable(ctr_q)); // R5
  AST_ERR_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_we && in_wide)); // R5
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (a == CAP_ADDR) |-> (bus_rdata == 64'h2000)); // R6
  AST_RDPORT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & ~WMASK) == 64'd0)); // R7
  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((ovf_status & $past(wrap)) == $past(wrap))); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && a == OVF_ADDR) |=> (($past(ovf_status) & ~ovf_status) == '0)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 64'd0)); // R12
  AST_UNMAPPED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> !bus_err); // R12

  for (genvar g = 0; g < int'(NUM_CTR); g++) begin : g_wrap
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[g] |=> (ctr_q[g] == '0)); // R10
  end

endmodule

bind perfctr_bank perfctr_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W),
  .NARROW_BASE(NARROW_BASE), .WIDE_BASE(WIDE_BASE),
  .CAP_ADDR(CAP_ADDR), .OVF_ADDR(OVF_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_err   (bus_err),
  .bus_rdata (bus_rdata),
  .evt_inc   (evt_inc),
  .ctr_en    (ctr_en),
  .rd_data   (rd_data),
  .ctr_q     (ctr_q),
  .wrap      (wrap),
  .ovf_status(ovf_status)
);

// File: tb/perfctr_bank_tb.sv
`timescale 1ns/1ps
module perfctr_bank_tb;
  localparam int N  = 4;
  localparam int W  = 48;
  localparam logic [63:0] MASK = (64'd1 << W) - 1;
  localparam logic [11:0] NB = 12'h0C1;
  localparam logic [11:0] WB = 12'h4C1;
  localparam logic [11:0] CAP = 12'h345;
  localparam logic [11:0] OVF = 12'h390;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [63:0] bus_rdata;
  logic        bus_err;
  logic [N-1:0] evt_inc = '0;
  logic [N-1:0] ctr_en = '0;
  logic [1:0]  rd_idx = '0;
  logic [63:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  perfctr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .evt_inc(evt_inc), .ctr_en(ctr_en), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, output logic err);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    #1 err = bus_err;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic side(input int i, output logic [63:0] d);
    rd_idx = 2'(i);
    #1 d = rd_data;
  endtask

  // Expected narrow-window value, computed with signed arithmetic.
  function automatic logic [63:0] exp_narrow(input logic [63:0] d);
    longint s;
    s = longint'(int'(d[31:0]));
    return 64'(s) & MASK;
  endfunction

  task automatic read_all(input string req, input int i, input logic [63:0] exp);
    logic [63:0] v;
    rd(NB + 12'(i), v); chk({req, " narrow read"}, v, exp);
    rd(WB + 12'(i), v); chk({req, " wide read"}, v, exp);
    side(i, v);         chk({req, " side port"}, v, exp);
  endtask

  logic [63:0] pats [9];

  initial begin
    logic [63:0] v;
    logic        e;
    logic [63:0] cur;
    pats[0] = 64'h0;
    pats[1] = 64'h1234_5678;
    pats[2] = 64'h8000_0001;
    pats[3] = 64'hFFFF_FFFF;
    pats[4] = 64'hFFFF_FF01_2345_6789;
    pats[5] = 64'h0000_FF01_2345_6789;
    pats[6] = 64'h0000_FFFF_FFFF_FFFF;
    pats[7] = 64'h0001_0000_0000_0000;
    pats[8] = 64'h7FFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13: reset state
    for (int i = 0; i < N; i++) read_all("R13", i, 64'd0);
    rd(OVF, v); chk("R13 status", v, 64'd0);
    rd(CAP, v); chk("R6 capability", v, 64'h2000);

    // R1 R2 R3: narrow window sweep
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 9; p++) begin
        wr(NB + 12'(i), pats[p], e);
        chk("R3 narrow no error", 64'(e), 64'd0);
        read_all("R1 R2", i, exp_narrow(pats[p]));
      end
    end

    // R4 R5: wide window sweep
    for (int i = 0; i < N; i++) begin
      wr(NB + 12'(i), 64'h55, e);
      cur = 64'h55;
      for (int p = 0; p < 9; p++) begin
        wr(WB + 12'(i), pats[p], e);
        if ((pats[p] & ~MASK) != 0) begin
          chk("R5 error raised", 64'(e), 64'd1);
        end else begin
          chk("R4 no error", 64'(e), 64'd0);
          cur = pats[p];
        end
        read_all("R4 R5 R7", i, cur);
      end
    end

    // R8: gating by event and enable
    for (int i = 0; i < N; i++) wr(NB + 12'(i), 64'd100, e);
    @(negedge clk); evt_inc = 4'b1111; ctr_en = 4'b0100;
    repeat (5) @(negedge clk);
    evt_inc = 4'b0000; ctr_en = 4'b1111;
    repeat (3) @(negedge clk);
    ctr_en = '0;
    read_all("R8 counted", 2, 64'd105);
    read_all("R8 idle", 0, 64'd100);
    read_all("R8 idle", 3, 64'd100);

    // R9: same-cycle write wins, counting resumes from the written value
    @(negedge clk);
    evt_inc = 4'b0010; ctr_en = 4'b0010;
    bus_addr = NB + 12'd1; bus_wdata = 64'd500; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    repeat (2) @(negedge clk);
    evt_inc = '0; ctr_en = '0;
    read_all("R9 write wins", 1, 64'd502);

    // R10 R11: wrap and sticky status
    wr(WB + 12'd3, 64'h0000_FFFF_FFFF_FFFF, e);
    rd(OVF, v); chk("R10 no flag before wrap", v, 64'd0);
    @(negedge clk); evt_inc = 4'b1000; ctr_en = 4'b1000;
    @(negedge clk); evt_inc = '0; ctr_en = '0;
    read_all("R10 wrapped", 3, 64'd0);
    rd(OVF, v); chk("R10 flag set", v, 64'h8);
    repeat (4) @(negedge clk);
    rd(OVF, v); chk("R11 sticky", v, 64'h8);
    wr(OVF, 64'h0, e);
    rd(OVF, v); chk("R11 zero mask keeps", v, 64'h8);
    wr(NB + 12'd0, 64'hFFFF_FFFF, e);
    @(negedge clk); evt_inc = 4'b0001; ctr_en = 4'b0001;
    @(negedge clk); evt_inc = '0; ctr_en = '0;
    rd(OVF, v); chk("R10 second flag", v, 64'h9);
    wr(OVF, 64'h8, e);
    rd(OVF, v); chk("R11 clear one bit", v, 64'h1);
    // R11: wrap and clear on the same edge -> bit stays set
    wr(NB + 12'd0, 64'hFFFF_FFFF, e);
    @(negedge clk);
    evt_inc = 4'b0001; ctr_en = 4'b0001;
    bus_addr = OVF; bus_wdata = 64'h1; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; evt_inc = '0; ctr_en = '0;
    rd(OVF, v); chk("R11 set beats clear", v, 64'h1);
    wr(OVF, 64'hF, e);
    rd(OVF, v); chk("R11 cleared", v, 64'h0);

    // R12: unmapped addresses around each window
    for (int i = 0; i < N; i++) wr(NB + 12'(i), 64'd7, e);
    wr(12'h0C0, 64'd99, e); chk("R12 no error 0C0", 64'(e), 64'd0);
    wr(12'h0C5, 64'd99, e); chk("R12 no error 0C5", 64'(e), 64'd0);
    wr(12'h4C0, 64'hFFFF_FFFF_FFFF_FFFF, e); chk("R12 no error 4C0", 64'(e), 64'd0);
    wr(12'h4C5, 64'hFFFF_FFFF_FFFF_FFFF, e); chk("R12 no error 4C5", 64'(e), 64'd0);
    rd(12'h0C0, v); chk("R12 read 0C0", v, 64'd0);
    rd(12'h0C5, v); chk("R12 read 0C5", v, 64'd0);
    rd(12'h4C0, v); chk("R12 read 4C0", v, 64'd0);
    rd(12'h4C5, v); chk("R12 read 4C5", v, 64'd0);
    for (int i = 0; i < N; i++) read_all("R12 untouched", i, 64'd7);
    wr(CAP, 64'hFFFF, e);
    rd(CAP, v); chk("R6 capability after write", v, 64'h2000);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule